// File: doc/BRIEF.md
# Burst Address Counter

This block sits in front of a synchronous memory array on one port and supplies the address that the array uses in each cycle. A caller either presents a fresh address with a load strobe or lets the block generate the following addresses itself, so a burst of reads or writes only needs the start address. Three active-low strobes are sampled on the rising clock edge: clear, load and advance. The address the array sees changes at the same edge that samples them.

The control is built as a small state machine whose state records which source produced the current address. There are four states. CLEAR means the address was forced to zero. LOAD means the external address was captured. STEP means the previous address plus one was taken. HOLD means the previous address was kept. Every edge is a transition from any state into exactly one of these four states. Clear wins over load, and load wins over advance. The transitions are:

- any → CLEAR when clear is low;
- any → LOAD when clear is high and load is low;
- any → STEP when clear and load are high and advance is low;
- any → HOLD when all three strobes are high.

Clearing costs no dead cycle: the cycle that clears the counter can also read or write address zero. The chip-select, byte-select and write inputs are accepted on the port list but have no influence on the counter.

Top module: `burst_addr_ctr`

## Requirements
- R1: While reset is asserted, and in the first cycle after it is released, `mem_addr` is 0.
- R2: With `clr_n` high and `load_n` low at an edge, `mem_addr` equals the `ext_addr` sampled at that edge from that edge onward.
- R3: With `clr_n` and `load_n` high and `adv_n` low at an edge, `mem_addr` becomes its previous value plus one.
- R4: With all three strobes high at an edge, `mem_addr` keeps its previous value.
- R5: `clr_n` low at an edge forces `mem_addr` to 0, whatever `load_n`, `adv_n` and `ext_addr` are.
- R6: When `load_n` and `adv_n` are both low (with `clr_n` high), the load takes effect and no increment is applied.
- R7: An advance from the all-ones address (2^AW − 1) gives address 0.
- R8: `sel0_n`, `sel1`, `ub_n`, `lb_n` and `we_n` have no effect on `mem_addr`. In particular, the counter advances while the port is deselected.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock; all strobes are sampled on its rising edge |
| rst_n | input | 1 | Asynchronous active-low reset |
| ext_addr | input | AW | External address captured by a load |
| load_n | input | 1 | Active-low load strobe |
| adv_n | input | 1 | Active-low advance strobe |
| clr_n | input | 1 | Active-low clear-to-zero strobe |
| sel0_n | input | 1 | Active-low chip select (no effect on the counter) |
| sel1 | input | 1 | Active-high chip select (no effect on the counter) |
| ub_n | input | 1 | Upper byte select (no effect on the counter) |
| lb_n | input | 1 | Lower byte select (no effect on the counter) |
| we_n | input | 1 | Write strobe (no effect on the counter) |
| mem_addr | output | AW | Address used by the array in the current cycle |

## Verification
The assertions assume that every strobe and `ext_addr` is at a known 0 or 1 value at each rising edge once reset is released. They also assume that the only way the address changes is through the four strobe combinations.

The stimulus meets these assumptions by driving every input from time zero and changing inputs only on falling edges. Random strobe patterns come from a fixed seed. Clear is kept rare so that long advance runs can build up. The random traffic is mixed with directed cases for priority, wrap at the all-ones address, and deselected advance.

// File: rtl/burst_addr_pkg.sv
package burst_addr_pkg;

    // Source of the address presented in the current cycle
    typedef enum logic [1:0] {
        SRC_HOLD  = 2'd0,
        SRC_STEP  = 2'd1,
        SRC_LOAD  = 2'd2,
        SRC_CLEAR = 2'd3
    } addr_src_e;

endpackage

// File: rtl/burst_addr_decode.sv
module burst_addr_decode
    import burst_addr_pkg::*;
(
    input  logic      load_n,
    input  logic      adv_n,
    input  logic      clr_n,
    output addr_src_e next_src
);

    // Fixed priority: clear, then load, then advance
    always_comb begin
        if (!clr_n)
            next_src = SRC_CLEAR;
        else if (!load_n)
            next_src = SRC_LOAD;
        else if (!adv_n)
            next_src = SRC_STEP;
        else
            next_src = SRC_HOLD;
    end

endmodule

// File: rtl/burst_addr_reg.sv
module burst_addr_reg
    import burst_addr_pkg::*;
#(
    parameter int AW = 15
) (
    input  logic          clk,
    input  logic          rst_n,
    input  addr_src_e     next_src,
    input  logic [AW-1:0] ext_addr,
    output logic [AW-1:0] addr_q
);

    localparam logic [AW-1:0] TOP_ADDR  = {AW{1'b1}};
    localparam logic [AW-1:0] ZERO_ADDR = '0;

    addr_src_e     src_q;
    logic [AW-1:0] addr_d;

    // State register: records which source produced the current address
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)
            src_q <= SRC_CLEAR;
        else
            src_q <= next_src;
    end

    // Output process: next address, chosen by the state being entered
    always_comb begin
        unique case (next_src)
            SRC_CLEAR: addr_d = ZERO_ADDR;
            SRC_LOAD:  addr_d = ext_addr;
            SRC_STEP:  addr_d = (addr_q == TOP_ADDR) ? ZERO_ADDR : addr_q + AW'(1);
            SRC_HOLD:  addr_d = addr_q;
            default:   addr_d = addr_q;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)
            addr_q <= ZERO_ADDR;
        else
            addr_q <= addr_d;
    end

    // R5: a clear leaves the counter at zero
    a_r5_clear_zero: assert property (@(posedge clk) disable iff (!rst_n)
        (src_q == SRC_CLEAR) |-> (addr_q == ZERO_ADDR));

    // R4: holding keeps the address
    a_r4_hold_stable: assert property (@(posedge clk) disable iff (!rst_n)
        (next_src == SRC_HOLD) |=> $stable(addr_q));

    // R7: advancing from all-ones lands on zero
    a_r7_wrap_zero: assert property (@(posedge clk) disable iff (!rst_n)
        (next_src == SRC_STEP && addr_q == TOP_ADDR) |=> (addr_q == ZERO_ADDR));

endmodule

// File: rtl/burst_addr_ctr.sv
module burst_addr_ctr
    import burst_addr_pkg::*;
#(
    parameter int AW = 15
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic [AW-1:0] ext_addr,
    input  logic          load_n,
    input  logic          adv_n,
    input  logic          clr_n,
    input  logic          sel0_n,
    input  logic          sel1,
    input  logic          ub_n,
    input  logic          lb_n,
    input  logic          we_n,
    output logic [AW-1:0] mem_addr
);

    localparam int DEPTH = 1 << AW;

    addr_src_e next_src;
    logic      unused_enables;

    // Enables and direction are deliberately not consulted (R8)
    assign unused_enables = ^{sel0_n, sel1, ub_n, lb_n, we_n};

    burst_addr_decode u_decode (
        .load_n   (load_n),
        .adv_n    (adv_n),
        .clr_n    (clr_n),
        .next_src (next_src)
    );

    burst_addr_reg #(.AW(AW)) u_reg (
        .clk      (clk),
        .rst_n    (rst_n),
        .next_src (next_src),
        .ext_addr (ext_addr),
        .addr_q   (mem_addr)
    );

    // R2 and R6: a load with clear inactive takes the external address
    a_r2_load_taken: assert property (@(posedge clk) disable iff (!rst_n)
        (clr_n && !load_n) |=> (mem_addr == $past(ext_addr)));

    // R3: advance without load or clear adds one modulo the depth
    a_r3_step_one: assert property (@(posedge clk) disable iff (!rst_n)
        (clr_n && load_n && !adv_n) |=>
        (32'(mem_addr) == ((32'($past(mem_addr)) + 32'd1) % 32'(DEPTH))));

    // R5: clear overrides everything
    a_r5_clear_wins: assert property (@(posedge clk) disable iff (!rst_n)
        !clr_n |=> (mem_addr == '0));

endmodule

// File: tb/burst_addr_ctr_tb_top.sv
module burst_addr_ctr_tb_top;

    localparam int AW = 15;
    localparam logic [AW-1:0] ALL1 = {AW{1'b1}};

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic [AW-1:0] ext_addr = '0;
    logic          load_n = 1'b1, adv_n = 1'b1, clr_n = 1'b1;
    logic          sel0_n = 1'b0, sel1 = 1'b1, ub_n = 1'b0, lb_n = 1'b0, we_n = 1'b1;
    logic [AW-1:0] mem_addr;

    int checks = 0;
    int errors = 0;
    bit done = 1'b0;
    logic [AW-1:0] model = '0;

    always #5 clk = ~clk;

    burst_addr_ctr #(.AW(AW)) dut_i (
        .clk(clk), .rst_n(rst_n), .ext_addr(ext_addr),
        .load_n(load_n), .adv_n(adv_n), .clr_n(clr_n),
        .sel0_n(sel0_n), .sel1(sel1), .ub_n(ub_n), .lb_n(lb_n), .we_n(we_n),
        .mem_addr(mem_addr)
    );

    function automatic logic [AW-1:0] ref_next(logic [AW-1:0] cur, logic [AW-1:0] ea,
                                               logic ld, logic av, logic cl);
        if (!cl)      return '0;
        else if (!ld) return ea;
        else if (!av) return cur + AW'(1);
        else          return cur;
    endfunction

    function automatic string tag_of(logic ld, logic av, logic cl);
        if (!cl)            return "R5";
        else if (!ld && !av) return "R6";
        else if (!ld)       return "R2";
        else if (!av)       return "R3";
        else                return "R4";
    endfunction

    task automatic check(string tag);
        checks++;
        if (mem_addr !== model) begin
            errors++;
            $display("FAIL %s actual %0h expected %0h", tag, mem_addr, model);
        end
    endtask

    task automatic drive(logic [AW-1:0] ea, logic ld, logic av, logic cl);
        ext_addr = ea; load_n = ld; adv_n = av; clr_n = cl;
    endtask

    // One clock edge, then compare on the falling edge
    task automatic tick(string tag);
        @(posedge clk);
        model = ref_next(model, ext_addr, load_n, adv_n, clr_n);
        @(negedge clk);
        check(tag);
    endtask

    initial begin
        #2_000_000;
        if (!done) begin
            errors++;
            $display("FAIL watchdog actual hung expected finish");
            $display("  CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

    initial begin
        void'($urandom(32'd1234));
        // R1: reset holds zero despite a load request
        drive(15'h1abc, 1'b0, 1'b0, 1'b1);
        repeat (3) @(negedge clk);
        model = '0;
        check("R1");
        drive('0, 1'b1, 1'b1, 1'b1);
        rst_n = 1'b1;
        tick("R1");

        drive(15'h0123, 1'b0, 1'b1, 1'b1); tick("R2");
        drive(15'h7777, 1'b1, 1'b0, 1'b1); tick("R3");
        tick("R3");
        drive(15'h5555, 1'b1, 1'b1, 1'b1); tick("R4");
        tick("R4");
        drive(15'h2222, 1'b0, 1'b0, 1'b0); tick("R5");
        drive(15'h0040, 1'b0, 1'b0, 1'b1); tick("R6");
        // R7: wrap from all ones
        drive(ALL1, 1'b0, 1'b1, 1'b1); tick("R2");
        drive(ALL1, 1'b1, 1'b0, 1'b1); tick("R7");
        // R8: deselected port, byte selects off, write: still advances
        sel0_n = 1'b1; sel1 = 1'b0; ub_n = 1'b1; lb_n = 1'b1; we_n = 1'b0;
        tick("R8");
        tick("R8");
        drive(15'h0100, 1'b1, 1'b1, 1'b1); tick("R8");

        for (int i = 0; i < 400; i++) begin
            logic cl;
            logic ld;
            logic av;
            cl = ($urandom % 16) != 0;
            ld = ($urandom % 4) != 0;
            av = $urandom % 2;
            drive(AW'($urandom), ld, av, cl);
            sel0_n = $urandom % 2; sel1 = $urandom % 2;
            ub_n = $urandom % 2; lb_n = $urandom % 2; we_n = $urandom % 2;
            tick(tag_of(ld, av, cl));
        end

        done = 1'b1;
        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

endmodule